// File: doc/BRIEF.md
# Correlated Double Sampling Hit Finder

This block sits behind the per-channel converters of a pixel matrix readout. Each row of pixels is sampled twice. The first sample is taken while the pixel still holds its signal charge, and the second is taken after the charge has been cleared. Both samples arrive as a channel-serial stream, and a phase flag tells the two apart. The block keeps the first sample of every column. When the matching second sample arrives, it subtracts that sample from the stored one. The pedestal and slow drifts cancel, and only the collected signal remains.

The difference is compared against a programmable threshold as the stream flows. Columns at or below the threshold are suppressed. Each column above it becomes one word in an on-chip hit memory. The word holds the row, the column and the amplitude. Entries are stored in arrival order, and the readout side fetches them through a synchronous read port.

A frame-start pulse opens a new frame. It empties the memory by zeroing the live hit count and clearing the overflow flag. At the same moment it latches the finished frame's count for readout. A double-row mode widens the accepted column range to twice the channel count, so that two physical rows read in parallel appear as one wide row.

Top module: `cds_hit_finder`

## Requirements
- R1: For a post-clear sample on column c, the stored amplitude is the last pre-clear sample of column c minus the post-clear sample, as an unsigned 8-bit value.
- R2: When the post-clear sample is larger than the stored pre-clear sample, the difference is clamped to zero, and no hit is recorded whatever the threshold.
- R3: A hit is recorded only when the difference is strictly greater than `thresh`. A difference equal to `thresh` is suppressed.
- R4: Hit words are written to consecutive addresses starting at 0 in arrival order. Each word has row index in bits [25:16], column index in bits [15:8] and amplitude in bits [7:0]. `rd_data` shows the word at `rd_addr` one clock after the address is presented.
- R5: `hit_count` rises by exactly one in the clock after each recorded hit and is otherwise unchanged within a frame.
- R6: Once 256 hits are stored, further hits are dropped. `hit_count` stays at 256, the stored words are unchanged, and `overflow` goes high and stays high until the next frame start.
- R7: A `frame_start` pulse copies the current `hit_count` into `frame_hits`, clears `overflow`, and restarts the count at 0. A hit arriving in the same clock as `frame_start` becomes word 0 of the new frame.
- R8: With `dbl_mode` low, samples on columns 128 and above are ignored in both phases. With `dbl_mode` high, columns 0 to 255 are accepted and reported with their full column index.
- R9: A later pre-clear sample on a column replaces the earlier one. The difference always uses the most recent pre-clear sample.
- R10: After reset, `hit_count`, `frame_hits` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-clock pulse opening a new frame |
| dbl_mode | input | 1 | 1: double-row mode, 256 columns accepted |
| thresh | input | 8 | Zero-suppression threshold (hit if difference > thresh) |
| smp_valid | input | 1 | Sample beat valid |
| smp_phase | input | 1 | 0: pre-clear sample, 1: post-clear sample |
| smp_row | input | 10 | Row index of the sample |
| smp_col | input | 8 | Column index of the sample |
| smp_data | input | 8 | Digitized sample value |
| rd_addr | input | 8 | Hit memory read address |
| rd_data | output | 26 | Hit word {row, column, amplitude}, one clock after rd_addr |
| hit_count | output | 9 | Hits stored in the current frame (0 to 256) |
| frame_hits | output | 9 | Hit count of the previous frame, latched at frame_start |
| overflow | output | 1 | Sticky: a hit was dropped because the memory was full |

## Verification
A full row is driven in which every group of four columns cycles through four cases. The first has a difference equal to the threshold, the second one above it, the third a post-clear sample larger than the pre-clear one, and the fourth a large positive difference. This pattern separates a strict comparison from an inclusive one, and a clamped subtraction from a wrapped one. A column is rewritten before its post-clear sample to show that the most recent pre-clear value is used. High columns are sent with the double-row mode both off and on, which exposes wrong range gating and a truncated column field. A fill past 256 hits, followed by a frame start that coincides with a hit, shows the drop behaviour, the sticky flag, the count capture and the new frame's first address.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic {
    PH_PRE  = 1'b0,
    PH_POST = 1'b1
  } phase_e;

  localparam int unsigned DEF_NUM_CH = 128;
  localparam int unsigned DEF_SMP_W  = 8;
  localparam int unsigned DEF_ROW_W  = 10;
  localparam int unsigned DEF_DEPTH  = 256;
endpackage

// File: rtl/cds_first_store.sv
module cds_first_store #(
  parameter int unsigned NUM_COL = 256,
  parameter int unsigned SMP_W   = 8,
  parameter int unsigned COL_W   = $clog2(NUM_COL)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [SMP_W-1:0] wr_data,
  input  logic [COL_W-1:0] rd_col,
  output logic [SMP_W-1:0] rd_data
);
  logic [SMP_W-1:0] held [NUM_COL];

  for (genvar i = 0; i < NUM_COL; i++) begin : g_col
    logic [SMP_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_col == COL_W'(i))) begin
        q <= wr_data;
      end
    end
    assign held[i] = q;
  end

  assign rd_data = held[rd_col];
endmodule

// File: rtl/cds_hit_detect.sv
module cds_hit_detect
  import cds_pkg::*;
#(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned COL_W  = $clog2(2 * NUM_CH)
) (
  input  logic             smp_valid,
  input  phase_e           smp_phase,
  input  logic [COL_W-1:0] smp_col,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [SMP_W-1:0] first_val,
  input  logic [SMP_W-1:0] thresh,
  input  logic             dbl_mode,
  output logic             col_ok,
  output logic             store_en,
  output logic             hit_event,
  output logic [SMP_W-1:0] hit_amp
);
  function automatic logic [SMP_W-1:0] sub_clamp(input logic [SMP_W-1:0] pre,
                                                 input logic [SMP_W-1:0] post);
    return (pre > post) ? (pre - post) : '0;
  endfunction

  function automatic logic above(input logic [SMP_W-1:0] amp,
                                 input logic [SMP_W-1:0] lim);
    return amp > lim;
  endfunction

  logic [SMP_W-1:0] diff;

  always_comb begin
    col_ok    = dbl_mode || (smp_col < COL_W'(NUM_CH));
    store_en  = smp_valid && col_ok && (smp_phase == PH_PRE);
    diff      = sub_clamp(first_val, smp_data);
    hit_amp   = diff;
    hit_event = smp_valid && col_ok && (smp_phase == PH_POST) && above(diff, thresh);
  end
endmodule

// File: rtl/cds_hit_ram.sv
module cds_hit_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned ENT_W = 26,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             hit_event,
  input  logic [ENT_W-1:0] hit_word,
  input  logic [AW-1:0]    rd_addr,
  output logic [ENT_W-1:0] rd_data,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] frame_hits,
  output logic             overflow,
  output logic             wr_accept,
  output logic             hit_drop
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] base;
  logic             ovf_base;

  always_comb begin
    base      = frame_start ? '0 : hit_count;
    ovf_base  = frame_start ? 1'b0 : overflow;
    wr_accept = hit_event && (base < CNT_W'(DEPTH));
    hit_drop  = hit_event && !wr_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      frame_hits <= '0;
      overflow   <= 1'b0;
    end else begin
      hit_count <= wr_accept ? base + 1'b1 : base;
      overflow  <= ovf_base | hit_drop;
      if (frame_start) begin
        frame_hits <= hit_count;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_accept) begin
      mem[base[AW-1:0]] <= hit_word;
    end
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cds_hit_finder.sv
module cds_hit_finder
  import cds_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned ROW_W  = DEF_ROW_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned NUM_COL = 2 * NUM_CH,
  localparam int unsigned COL_W   = $clog2(NUM_COL),
  localparam int unsigned ENT_W   = ROW_W + COL_W + SMP_W,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             dbl_mode,
  input  logic [SMP_W-1:0] thresh,
  input  logic             smp_valid,
  input  logic             smp_phase,
  input  logic [ROW_W-1:0] smp_row,
  input  logic [COL_W-1:0] smp_col,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [ENT_W-1:0] rd_data,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] frame_hits,
  output logic             overflow
);
  phase_e           phase;
  logic [SMP_W-1:0] first_val;
  logic             col_ok;
  logic             store_en;
  logic             hit_event;
  logic [SMP_W-1:0] hit_amp;
  logic [ENT_W-1:0] hit_word;
  logic             wr_accept;
  logic             hit_drop;

  assign phase    = phase_e'(smp_phase);
  assign hit_word = {smp_row, smp_col, hit_amp};

  cds_first_store #(
    .NUM_COL (NUM_COL),
    .SMP_W   (SMP_W),
    .COL_W   (COL_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (store_en),
    .wr_col  (smp_col),
    .wr_data (smp_data),
    .rd_col  (smp_col),
    .rd_data (first_val)
  );

  cds_hit_detect #(
    .NUM_CH (NUM_CH),
    .SMP_W  (SMP_W),
    .COL_W  (COL_W)
  ) u_detect (
    .smp_valid (smp_valid),
    .smp_phase (phase),
    .smp_col   (smp_col),
    .smp_data  (smp_data),
    .first_val (first_val),
    .thresh    (thresh),
    .dbl_mode  (dbl_mode),
    .col_ok    (col_ok),
    .store_en  (store_en),
    .hit_event (hit_event),
    .hit_amp   (hit_amp)
  );

  cds_hit_ram #(
    .DEPTH (DEPTH),
    .ENT_W (ENT_W),
    .AW    (AW),
    .CNT_W (CNT_W)
  ) u_ram (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .hit_event   (hit_event),
    .hit_word    (hit_word),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .hit_count   (hit_count),
    .frame_hits  (frame_hits),
    .overflow    (overflow),
    .wr_accept   (wr_accept),
    .hit_drop    (hit_drop)
  );
endmodule

// File: rtl/cds_hit_finder_chk.sv
module cds_hit_finder_chk #(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned CNT_W  = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             dbl_mode,
  input logic             smp_valid,
  input logic [COL_W-1:0] smp_col,
  input logic [SMP_W-1:0] thresh,
  input logic             hit_event,
  input logic [SMP_W-1:0] hit_amp,
  input logic             hit_drop,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] frame_hits,
  input logic             overflow
);
  assert_hit_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_event |-> (hit_amp > thresh));

  assert_clamp_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_event |-> (hit_amp != '0));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (hit_count == $past(hit_count)) ||
                     (hit_count == $past(hit_count) + 1'b1));

  assert_no_overfill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= CNT_W'(DEPTH));

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !frame_start) |=> overflow);

  assert_overflow_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(hit_count) == CNT_W'(DEPTH)));

  assert_drop_holds_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_drop && !frame_start) |=> (hit_count == CNT_W'(DEPTH)) && overflow);

  assert_frame_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (frame_hits == $past(hit_count)) && !overflow &&
                    (hit_count <= CNT_W'(1)));

  assert_col_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !dbl_mode && (smp_col >= COL_W'(NUM_CH))) |-> !hit_event);
endmodule

bind cds_hit_finder cds_hit_finder_chk #(
  .NUM_CH (NUM_CH),
  .SMP_W  (SMP_W),
  .COL_W  (COL_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .dbl_mode    (dbl_mode),
  .smp_valid   (smp_valid),
  .smp_col     (smp_col),
  .thresh      (thresh),
  .hit_event   (hit_event),
  .hit_amp     (hit_amp),
  .hit_drop    (hit_drop),
  .hit_count   (hit_count),
  .frame_hits  (frame_hits),
  .overflow    (overflow)
);

// File: tb/test_cds_hit_finder.sv
module test_cds_hit_finder;
  localparam int NCH = 128;
  localparam int DEP = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        dbl_mode = 1'b0;
  logic [7:0]  thresh = 8'd10;
  logic        smp_valid = 1'b0;
  logic        smp_phase = 1'b0;
  logic [9:0]  smp_row = '0;
  logic [7:0]  smp_col = '0;
  logic [7:0]  smp_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [25:0] rd_data;
  logic [8:0]  hit_count;
  logic [8:0]  frame_hits;
  logic        overflow;

  int total = 0;
  int bad = 0;
  int seen = 0;
  int mcount = 0;
  bit movf = 0;
  int mcap = 0;
  logic [7:0]  fb [256];
  logic [25:0] q [$];

  always #2.5 clk = ~clk;

  cds_hit_finder i_cds_hit_finder (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dbl_mode(dbl_mode),
    .thresh(thresh), .smp_valid(smp_valid), .smp_phase(smp_phase),
    .smp_row(smp_row), .smp_col(smp_col), .smp_data(smp_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hit_count(hit_count),
    .frame_hits(frame_hits), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Driver: one sample per clock; the model pushes expected hit words.
  task automatic smp(input bit ph, input int row, input int col, input int d,
                     input bit fs = 1'b0);
    bit ok;
    int diff;
    frame_start = fs;
    smp_valid = 1'b1;
    smp_phase = ph;
    smp_row = 10'(row);
    smp_col = 8'(col);
    smp_data = 8'(d);
    if (fs) begin
      mcap = mcount;
      mcount = 0;
      movf = 0;
    end
    ok = dbl_mode || (col < NCH);
    if (ok) begin
      if (!ph) fb[col] = 8'(d);
      else begin
        diff = (int'(fb[col]) > d) ? int'(fb[col]) - d : 0;
        if (diff > int'(thresh)) begin
          if (mcount < DEP) begin
            q.push_back({10'(row), 8'(col), 8'(diff)});
            mcount++;
          end else movf = 1;
        end
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    frame_start = 1'b0;
  endtask

  task automatic pair(input int row, input int col, input int a, input int b);
    smp(1'b0, row, col, a);
    smp(1'b1, row, col, b);
  endtask

  task automatic drain();
    for (int k = 0; k < 2000; k++) begin
      if (seen == int'(hit_count) && q.size() == 0) break;
      @(negedge clk);
    end
    check(q.size() == 0, "R4 queue drained", q.size(), 0);
  endtask

  task automatic new_frame();
    frame_start = 1'b1;
    mcap = mcount;
    mcount = 0;
    movf = 0;
    @(negedge clk);
    frame_start = 1'b0;
    seen = 0;
  endtask

  // Monitor: reads each newly stored word and compares it with the queue.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && seen < int'(hit_count)) begin
        rd_addr = 8'(seen);
        @(negedge clk);
        if (q.size() == 0) begin
          check(1'b0, "R4 unexpected word", int'(rd_data), -1);
        end else begin
          logic [25:0] e;
          e = q.pop_front();
          check(rd_data == e, "R1/R4 hit word", int'(rd_data), int'(e));
        end
        seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(hit_count == 0, "R10 count", int'(hit_count), 0);
    check(frame_hits == 0, "R10 frame_hits", int'(frame_hits), 0);
    check(overflow == 0, "R10 overflow", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2/R3: full row with four cases per group of columns
    for (int c = 0; c < NCH; c++) smp(1'b0, 3, c, 100 + (c % 100));
    for (int c = 0; c < NCH; c++) begin
      int f;
      f = 100 + (c % 100);
      case (c % 4)
        0: smp(1'b1, 3, c, f - 10);
        1: smp(1'b1, 3, c, f - 11);
        2: smp(1'b1, 3, c, f + 5);
        default: smp(1'b1, 3, c, 0);
      endcase
    end
    check(int'(hit_count) == mcount, "R5 row count", int'(hit_count), mcount);
    check(mcount == 64, "R3 model row hits", mcount, 64);

    // R3: equal to threshold suppressed, one above recorded
    c0 = int'(hit_count);
    pair(4, 0, 50, 40);
    check(int'(hit_count) == c0, "R3 equal suppressed", int'(hit_count), c0);
    pair(4, 0, 50, 39);
    check(int'(hit_count) == c0 + 1, "R3 above recorded", int'(hit_count), c0 + 1);

    // R2: negative difference never a hit, even with zero threshold
    thresh = 8'd0;
    c0 = int'(hit_count);
    pair(4, 1, 20, 21);
    check(int'(hit_count) == c0, "R2 clamp no hit", int'(hit_count), c0);
    thresh = 8'd10;

    // R9: later pre-clear sample replaces earlier one (amp 180)
    smp(1'b0, 5, 5, 50);
    smp(1'b0, 5, 5, 200);
    smp(1'b1, 5, 5, 20);

    // R8: high column ignored in single mode, accepted in double mode
    c0 = int'(hit_count);
    pair(6, 200, 250, 0);
    check(int'(hit_count) == c0, "R8 single mode ignore", int'(hit_count), c0);
    smp(1'b0, 6, 201, 90);
    dbl_mode = 1'b1;
    smp(1'b1, 6, 201, 0);
    check(int'(hit_count) == c0, "R8 ignored first not stored", int'(hit_count), c0);
    pair(6, 255, 240, 10);
    check(int'(hit_count) == c0 + 1, "R8 double mode accept", int'(hit_count), c0 + 1);
    dbl_mode = 1'b0;

    drain();
    // R7: frame capture and clear
    new_frame();
    check(int'(frame_hits) == mcap, "R7 frame_hits", int'(frame_hits), mcap);
    check(hit_count == 0, "R7 count cleared", int'(hit_count), 0);

    // R6: fill past capacity
    thresh = 8'd0;
    for (int i = 0; i < DEP + 4; i++) pair(7, i % NCH, 1 + (i % 200), 0);
    check(int'(hit_count) == DEP, "R6 count saturates", int'(hit_count), DEP);
    check(overflow == 1'b1, "R6 overflow set", int'(overflow), 1);
    check(movf == 1, "R6 model overflow", int'(movf), 1);
    repeat (3) @(negedge clk);
    check(overflow == 1'b1, "R6 overflow sticky", int'(overflow), 1);
    drain();
    new_frame();
    check(int'(frame_hits) == DEP, "R7 frame_hits full", int'(frame_hits), DEP);
    check(overflow == 1'b0, "R7 overflow cleared", int'(overflow), 0);

    // R7: hit in the same clock as frame_start lands at word 0
    thresh = 8'd10;
    pair(8, 2, 70, 30);
    drain();
    smp(1'b0, 9, 3, 90);
    smp(1'b1, 9, 3, 20, 1'b1);
    seen = 0;
    check(int'(frame_hits) == 1, "R7 capture before same-clock hit", int'(frame_hits), 1);
    check(hit_count == 1, "R7 same-clock hit counted", int'(hit_count), 1);
    drain();

    summary();
  end
endmodule